// File: doc/BRIEF.md
# Frame-Atomic Shadowed Configuration Register Bank

This block holds a small window of display configuration words in two copies. The CPU sees a staging copy that it may rewrite at any time through a 32-bit register port with byte addresses on a four-byte stride. The pixel pipeline sees an active copy, which changes only on a cycle where the vertical-blank pulse is high. A change therefore takes effect for a whole frame and never in the middle of one.

A control word picks between two update modes. With autoload on, every blank pulse copies the whole staging window into the active copy. With autoload off, software stages a frame and then sets a load-request bit. That bit arms a single transfer at the next blank and reads back as 1 until the transfer has happened, so software can poll it before it stages the next frame. A request written in the same cycle as a blank pulse waits for the blank that follows.

Reads return the staging value. Software can therefore change some bits of a word by read-modify-write and keep the others. The window accepts full-word writes of zero, which lets software clear the whole window to a known state.

Top module: `shreg_bank`

## Requirements
- R1: After reset every active word is zero, every staging word and the control word read zero, and no transfer is pending.
- R2: An aligned full-word write inside the window (default base 0x800, 8 words, byte offset 0x800 + 4*index) can be read back on the next cycle. The active copy does not change until a blank pulse moves it.
- R3: With autoload on (control bit 1 = 0), each cycle with `vblank` high copies every staging word into the active copy. The new values appear after that clock edge, and `act_upd` is high in that cycle.
- R4: With autoload off (control bit 1 = 1), a blank pulse with no request pending leaves the active copy unchanged. The active copy never changes in a cycle without a blank pulse.
- R5: With autoload off, writing the control word (default offset 0x000) with bit 0 = 1 arms a transfer, and bit 0 then reads 1. The next blank pulse loads the staging window into the active copy, and bit 0 reads 0 after that edge.
- R6: A load request written in the same cycle as a blank pulse is not serviced by that pulse. It stays pending and is serviced by the next blank pulse.
- R7: With autoload on, the request bit has no effect and reads 0, even when it is written as 1.
- R8: In the control word, bit 1 is the autoload-disable bit and bit 0 is the request bit. Both may be written in one word. All other control bits read 0.
- R9: Writes to a misaligned address, or to an address outside both the control word and the window, change nothing. Reads from such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe for one full word |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Combinational read data for `cpu_addr` |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| act_flat | output | NUM_REGS*DATA_W | Active copy, word i at bits [i*DATA_W +: DATA_W] |
| act_upd | output | 1 | High in the cycle whose edge loads the active copy |

## Verification
The assertions assume that `vblank` is a synchronous pulse and that a write is a single full word with its address stable in the strobe cycle. They also assume that reset is held for at least one edge. The bench drives every input on the falling edge, raises `vblank` for exactly one cycle, and never overlaps a staging write with a blank unless the case under test is a control write that lands on the blank. Reads are sampled on the falling edge after the edge under test, so each result reflects exactly one update.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  localparam int CTL_REQ_BIT = 0;
  localparam int CTL_DIS_BIT = 1;

  // True when a byte address lands on an aligned word of the window.
  function automatic logic win_hit(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input int unsigned nwords);
    logic [31:0] top;
    top = base + 32'(nwords * 4);
    return (addr[1:0] == 2'b00) && (addr >= base) && (addr < top);
  endfunction

  // Word index of an address inside the window.
  function automatic logic [31:0] win_index(input logic [31:0] addr,
                                            input logic [31:0] base);
    logic [31:0] diff;
    diff = addr - base;
    return diff >> 2;
  endfunction

  // Read image of the control word.
  function automatic logic [31:0] ctl_image(input logic dis, input logic pend);
    logic [31:0] w;
    w = '0;
    w[CTL_DIS_BIT] = dis;
    w[CTL_REQ_BIT] = dis & pend;
    return w;
  endfunction

endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
  import shreg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0800,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 16'h0000,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              ctl_sel,
  output logic              win_sel,
  output logic [IDX_W-1:0]  win_idx,
  output logic              ctl_wr,
  output logic              win_wr
);

  logic [31:0] addr32;
  logic [31:0] idx32;

  assign addr32  = 32'(cpu_addr);
  assign ctl_sel = (cpu_addr == CTL_OFS);
  assign win_sel = win_hit(addr32, 32'(WIN_BASE), NUM_REGS);
  assign idx32   = win_index(addr32, 32'(WIN_BASE));
  assign win_idx = IDX_W'(idx32);
  assign ctl_wr  = cpu_wr & ctl_sel;
  assign win_wr  = cpu_wr & win_sel;

endmodule

// File: rtl/shreg_commit.sv
module shreg_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  input  logic ctl_wr,
  input  logic wr_dis,
  input  logic wr_req,
  output logic dis,
  output logic pending,
  output logic arm,
  output logic load_evt
);

  logic auto_fire;
  logic manual_fire;
  logic pend_nxt;

  // A request arms only if the same word leaves autoload disabled.
  assign arm         = ctl_wr & wr_dis & wr_req;
  assign auto_fire   = ~dis & vblank;
  // A request landing on this blank is held for the next one.
  assign manual_fire = dis & pending & vblank & ~arm;
  assign load_evt    = auto_fire | manual_fire;

  always_comb begin
    pend_nxt = pending;
    if (manual_fire) pend_nxt = 1'b0;
    if (ctl_wr) begin
      if (arm)          pend_nxt = 1'b1;
      else if (!wr_dis) pend_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis     <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (ctl_wr) dis <= wr_dis;
      pending <= pend_nxt;
    end
  end

endmodule

// File: rtl/shreg_store.sv
module shreg_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_wr,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic                       load_evt,
  output logic [DATA_W-1:0]          stg_rdata,
  output logic [NUM_REGS*DATA_W-1:0] act_flat
);

  logic [DATA_W-1:0] stg [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    logic [DATA_W-1:0] act_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[gi] <= '0;
      end else if (win_wr && (wr_idx == IDX_W'(gi))) begin
        stg[gi] <= wr_data;
      end
    end

    // The active word takes the staging value held before this edge.
    always_ff @(posedge clk) begin
      if (!rst_n)        act_q <= '0;
      else if (load_evt) act_q <= stg[gi];
    end

    assign act_flat[gi*DATA_W +: DATA_W] = act_q;
  end

  always_comb begin
    stg_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) stg_rdata = stg[i];
    end
  end

endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
  import shreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0800,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 16'h0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_wr,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic [DATA_W-1:0]          cpu_rdata,
  input  logic                       vblank,
  output logic [NUM_REGS*DATA_W-1:0] act_flat,
  output logic                       act_upd
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             ctl_sel;
  logic             win_sel;
  logic [IDX_W-1:0] win_idx;
  logic             ctl_wr;
  logic             win_wr;
  logic             dis;
  logic             pending;
  logic             arm;
  logic             load_evt;
  logic [DATA_W-1:0] stg_rdata;
  logic [31:0]       ctl_word;

  shreg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .WIN_BASE(WIN_BASE), .CTL_OFS(CTL_OFS)
  ) u_dec (
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .ctl_sel(ctl_sel), .win_sel(win_sel), .win_idx(win_idx),
    .ctl_wr(ctl_wr), .win_wr(win_wr)
  );

  shreg_commit u_cmt (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .ctl_wr(ctl_wr),
    .wr_dis(cpu_wdata[CTL_DIS_BIT]), .wr_req(cpu_wdata[CTL_REQ_BIT]),
    .dis(dis), .pending(pending), .arm(arm), .load_evt(load_evt)
  );

  shreg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_st (
    .clk(clk), .rst_n(rst_n),
    .win_wr(win_wr), .wr_idx(win_idx), .wr_data(cpu_wdata),
    .rd_idx(win_idx), .load_evt(load_evt),
    .stg_rdata(stg_rdata), .act_flat(act_flat)
  );

  assign ctl_word = ctl_image(dis, pending);
  assign act_upd  = load_evt;

  always_comb begin
    if (ctl_sel)      cpu_rdata = DATA_W'(ctl_word);
    else if (win_sel) cpu_rdata = stg_rdata;
    else              cpu_rdata = '0;
  end

endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk #(
  parameter int ACT_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vblank,
  input logic             ctl_wr,
  input logic             arm,
  input logic             dis,
  input logic             pending,
  input logic             load_evt,
  input logic [ACT_W-1:0] act_flat
);

  AST_LOAD_NEEDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> vblank); // R4

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act_flat)); // R4

  AST_AUTO_EVERY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis && vblank) |-> load_evt); // R3

  AST_ARM_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pending); // R5

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && pending && !vblank && !ctl_wr) |=> pending); // R5

  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && pending && vblank && !ctl_wr) |=> !pending); // R5

  AST_ARM_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && dis) |-> !load_evt); // R6

  AST_AUTO_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !dis |-> !pending); // R7

endmodule

bind shreg_bank shreg_bank_chk #(.ACT_W(NUM_REGS*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .ctl_wr(ctl_wr),
  .arm(arm), .dis(dis), .pending(pending), .load_evt(load_evt),
  .act_flat(act_flat)
);

// File: tb/sim_shreg_bank.sv
module sim_shreg_bank;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int NREG   = 8;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_BLK = 2'd2;
  localparam logic [1:0] OP_ACT = 2'd3;

  // {req[3:0], op[1:0], addr[15:0], data[31:0], expect[31:0]}
  localparam int NVEC = 24;
  localparam logic [85:0] VEC [NVEC] = '{
    {4'd1, OP_RD,  16'h0000, 32'h0,         32'h0},          // R1 ctl zero
    {4'd1, OP_RD,  16'h0804, 32'h0,         32'h0},          // R1 staging zero
    {4'd2, OP_WR,  16'h0800, 32'hA5A5_0001, 32'h0},
    {4'd2, OP_RD,  16'h0800, 32'h0,         32'hA5A5_0001},  // R2 readback
    {4'd2, OP_ACT, 16'd0,    32'h0,         32'h0},          // R2 active held
    {4'd3, OP_BLK, 16'h0,    32'h0,         32'h0},
    {4'd3, OP_ACT, 16'd0,    32'h0,         32'hA5A5_0001},  // R3 autoload
    {4'd8, OP_WR,  16'h0000, 32'h0000_0002, 32'h0},
    {4'd8, OP_RD,  16'h0000, 32'h0,         32'h0000_0002},  // R8 dis bit
    {4'd4, OP_WR,  16'h0804, 32'h1234_5678, 32'h0},
    {4'd4, OP_BLK, 16'h0,    32'h0,         32'h0},
    {4'd4, OP_ACT, 16'd1,    32'h0,         32'h0},          // R4 no load
    {4'd5, OP_WR,  16'h0000, 32'h0000_0003, 32'h0},
    {4'd5, OP_RD,  16'h0000, 32'h0,         32'h0000_0003},  // R5 pending
    {4'd5, OP_ACT, 16'd1,    32'h0,         32'h0},          // R5 waits
    {4'd5, OP_BLK, 16'h0,    32'h0,         32'h0},
    {4'd5, OP_RD,  16'h0000, 32'h0,         32'h0000_0002},  // R5 cleared
    {4'd5, OP_ACT, 16'd1,    32'h0,         32'h1234_5678},  // R5 loaded
    {4'd7, OP_WR,  16'h0000, 32'hFFFF_FFF1, 32'h0},
    {4'd7, OP_RD,  16'h0000, 32'h0,         32'h0},          // R7 req ignored
    {4'd3, OP_WR,  16'h081C, 32'hDEAD_BEEF, 32'h0},
    {4'd3, OP_BLK, 16'h0,    32'h0,         32'h0},
    {4'd3, OP_ACT, 16'd7,    32'h0,         32'hDEAD_BEEF},  // R3 last word
    {4'd2, OP_RD,  16'h0800, 32'h0,         32'hA5A5_0001}   // R2 kept
  };

  logic                     clk;
  logic                     rst_n;
  logic                     cpu_wr;
  logic [ADDR_W-1:0]        cpu_addr;
  logic [DATA_W-1:0]        cpu_wdata;
  logic [DATA_W-1:0]        cpu_rdata;
  logic                     vblank;
  logic [NREG*DATA_W-1:0]   act_flat;
  logic                     act_upd;

  int n_chk;
  int n_err;

  shreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vblank(vblank),
    .act_flat(act_flat), .act_upd(act_upd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic blank();
    @(negedge clk);
    vblank = 1'b1;
    @(posedge clk); #1;
    vblank = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] a,
                    input logic [31:0] exp);
    @(negedge clk);
    cpu_addr = a;
    #1;
    check(req, cpu_rdata, exp);
  endtask

  task automatic act(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk);
    check(req, act_flat[idx*DATA_W +: DATA_W], exp);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0; vblank = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    act("R1", 0, 32'h0);
    for (int i = 0; i < NVEC; i++) begin
      logic [85:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[85:82]);
      case (v[81:80])
        OP_WR:  wr(v[79:64], v[63:32]);
        OP_BLK: blank();
        OP_RD:  rd(tag, v[79:64], v[31:0]);
        default: act(tag, int'(v[79:64]), v[31:0]);
      endcase
    end

    // R9: misaligned and out-of-range writes change nothing, reads give 0
    wr(16'h0802, 32'hFFFF_FFFF);
    rd("R9", 16'h0800, 32'hA5A5_0001);
    rd("R9", 16'h0802, 32'h0);
    wr(16'h0820, 32'h5555_5555);
    rd("R9", 16'h0820, 32'h0);
    rd("R9", 16'h081C, 32'hDEAD_BEEF);

    // R2: full-word zero write accepted
    wr(16'h0800, 32'h0);
    rd("R2", 16'h0800, 32'h0);

    // R6: request landing on a blank waits for the next blank
    wr(16'h0000, 32'h2);
    wr(16'h0808, 32'h0000_0077);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 16'h0000; cpu_wdata = 32'h3; vblank = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0; vblank = 1'b0;
    act("R6", 2, 32'h0);
    rd("R6", 16'h0000, 32'h3);
    blank();
    act("R6", 2, 32'h0000_0077);
    rd("R6", 16'h0000, 32'h2);

    // R7: switching back to autoload drops a pending request
    wr(16'h0000, 32'h3);
    wr(16'h0000, 32'h1);
    rd("R7", 16'h0000, 32'h0);

    // R1: reset clears both copies
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    act("R1", 0, 32'h0);
    act("R1", 2, 32'h0);
    rd("R1", 16'h0808, 32'h0);
    rd("R1", 16'h0000, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule